// File: doc/BRIEF.md
# Per-Area External Bus Interface

This block connects an on-chip requester to an external asynchronous memory bus. The 24-bit external address space is cut into eight equal regions, picked by the top three address bits. Each region has its own active-low chip select line. Each region also has its own settings: data path width (8 or 16 bits), access length (a short two-state cycle or a longer three-state cycle) and a count of extra wait states. The wait states only lengthen the three-state form.

The requester presents an address, a byte/word size flag, a direction and write data, with a one-cycle valid strobe, while the block is idle. The block drives the address, data lanes, read strobe, two write strobes (upper and lower byte lane) and the chip selects. When the access is over, it raises a done pulse and holds the read data. A word access to an 8-bit region becomes two back-to-back byte cycles on the upper lane, with the even byte first. Region settings are taken when the request is accepted and hold until the access ends.

Top module: `ext_area_bus`

## Requirements
- R1: While an access runs, exactly the chip select whose index equals request address bits 23:21 is low. All chip selects are high when idle.
- R2: The chip select stays low without a gap for the whole access, including wait states and both halves of a split word. It is low for exactly phases × states cycles.
- R3: A region set for the short form (slow bit 0) takes 2 bus states per byte phase. The read or write strobe is low only in the second state.
- R4: A region set for the long form (slow bit 1) with wait field W (0..3) takes 3+W states per phase. The read strobe is low for 2+W of them. The write strobe is low for 1+W of them and rises one state before the phase ends.
- R5: The wait field has no effect on a short-form region.
- R6: On a 16-bit region (wide bit 1), a word uses address bit 0 = 0 and both lanes, with the even byte on bits 15:8. A byte at an even address uses the upper lane (bits 15:8, upper write strobe). A byte at an odd address uses the lower lane (bits 7:0, lower write strobe).
- R7: On an 8-bit region (wide bit 0), only the upper lane and upper write strobe are used. A word is split into two phases: address with bit 0 cleared carrying bits 15:8 of the word, then address +1 carrying bits 7:0.
- R8: Done is high for exactly one cycle, in the cycle after the last bus state. At that point the read data holds `{even byte, odd byte}` for a word, or `{8'h00, byte}` for a byte. The read data is held until the next read ends.
- R9: A request presented while an access is running is ignored. It causes no chip select for its region and no extra done.
- R10: During reset all chip selects and strobes are high and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide_i | input | 8 | Per-region 16-bit width select (bit k = region k) |
| cfg_slow_i | input | 8 | Per-region three-state cycle select |
| cfg_wait_i | input | 16 | Per-region wait count, 2 bits per region at [2k+1:2k] |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_addr_i | input | 24 | Request byte address |
| req_word_i | input | 1 | 1 = word, 0 = byte |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 16 | Write data (byte writes use bits 7:0) |
| rdata_o | output | 16 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| ext_addr_o | output | 24 | External address |
| ext_dout_o | output | 16 | External write data |
| ext_din_i | input | 16 | External read data |
| ext_oe_o | output | 1 | Write data drive enable |
| ext_rd_n_o | output | 1 | Read strobe, active low |
| ext_wr_hi_n_o | output | 1 | Upper-lane write strobe, active low |
| ext_wr_lo_n_o | output | 1 | Lower-lane write strobe, active low |
| ext_cs_n_o | output | 8 | Chip selects, active low |

## Verification
Two events can meet in one cycle: a new request arriving, and an access that is still sequencing strobes and chip select. The bench provokes this on every access. In the first bus state it holds the valid strobe high with the address moved to the neighbouring region. The collision is judged by three results: no foreign chip select cycles, exactly one done, and an idle bus with done low in the cycle after completion. All of this is checked across a sweep of every region, width, cycle form, wait count, size, direction and low address bit.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
  parameter int unsigned WAIT_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4
  } bus_st_e;

  typedef struct packed {
    logic              wide;
    logic              slow;
    logic [WAIT_W-1:0] waits;
  } area_cfg_t;
endpackage

// File: rtl/ebi_area_decode.sv
module ebi_area_decode
  import ebi_pkg::*;
#(
  parameter  int unsigned ADDR_W    = 24,
  parameter  int unsigned AREAS     = 8,
  localparam int unsigned AREA_BITS = $clog2(AREAS)
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [AREAS-1:0]        cfg_wide_i,
  input  logic [AREAS-1:0]        cfg_slow_i,
  input  logic [AREAS*WAIT_W-1:0] cfg_wait_i,
  output logic [AREA_BITS-1:0]    area_o,
  output area_cfg_t               cfg_o
);
  area_cfg_t cfg_tab [AREAS];

  for (genvar g = 0; g < AREAS; g++) begin : g_area
    assign cfg_tab[g].wide  = cfg_wide_i[g];
    assign cfg_tab[g].slow  = cfg_slow_i[g];
    assign cfg_tab[g].waits = cfg_wait_i[g*WAIT_W +: WAIT_W];
  end

  assign area_o = addr_i[ADDR_W-1 -: AREA_BITS];
  assign cfg_o  = cfg_tab[area_o];
endmodule

// File: rtl/ebi_bus_fsm.sv
module ebi_bus_fsm
  import ebi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              slow_i,
  input  logic [WAIT_W-1:0] waits_i,
  input  logic              split_i,
  output bus_st_e           state_o,
  output logic              phase_o,
  output logic              phase_end_o,
  output logic              done_o
);
  bus_st_e           st_q, st_n;
  logic [WAIT_W-1:0] wc_q, wc_n;
  logic              ph_q, ph_n;
  logic              done_q, done_n;
  logic              phase_end;
  logic              more;

  assign more = split_i && !ph_q;

  always_comb begin
    st_n      = st_q;
    wc_n      = wc_q;
    ph_n      = ph_q;
    phase_end = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_n = ST_T1;
          ph_n = 1'b0;
        end
      end
      ST_T1: st_n = ST_T2;
      ST_T2: begin
        if (!slow_i) begin
          phase_end = 1'b1;
        end else if (waits_i == '0) begin
          st_n = ST_T3;
        end else begin
          st_n = ST_TW;
          wc_n = waits_i - WAIT_W'(1);
        end
      end
      ST_TW: begin
        if (wc_q == '0) st_n = ST_T3;
        else            wc_n = wc_q - WAIT_W'(1);
      end
      ST_T3:   phase_end = 1'b1;
      default: st_n = ST_IDLE;
    endcase
    if (phase_end) begin
      if (more) begin
        st_n = ST_T1;
        ph_n = 1'b1;
      end else begin
        st_n = ST_IDLE;
      end
    end
    done_n = phase_end && !more;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wc_q   <= '0;
      ph_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      wc_q   <= wc_n;
      ph_q   <= ph_n;
      done_q <= done_n;
    end
  end

  assign state_o     = st_q;
  assign phase_o     = ph_q;
  assign phase_end_o = phase_end;
  assign done_o      = done_q;
endmodule

// File: rtl/ebi_lane_steer.sv
module ebi_lane_steer #(
  parameter  int unsigned DATA_W = 16,
  localparam int unsigned HALF   = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_i,
  input  logic              word_i,
  input  logic              a0_i,
  input  logic              phase_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              hi_en_o,
  output logic              lo_en_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rdata_q, rdata_n;
  logic [HALF-1:0]   wb_lo, wb_hi, din_hi, din_lo;

  assign wb_lo  = wdata_i[HALF-1:0];
  assign wb_hi  = wdata_i[DATA_W-1:HALF];
  assign din_lo = din_i[HALF-1:0];
  assign din_hi = din_i[DATA_W-1:HALF];

  always_comb begin
    if (wide_i && word_i) begin
      dout_o  = wdata_i;
      hi_en_o = 1'b1;
      lo_en_o = 1'b1;
    end else if (wide_i) begin
      dout_o  = {wb_lo, wb_lo};
      hi_en_o = !a0_i;
      lo_en_o = a0_i;
    end else if (word_i) begin
      dout_o  = phase_i ? {wb_lo, wb_lo} : {wb_hi, wb_hi};
      hi_en_o = 1'b1;
      lo_en_o = 1'b0;
    end else begin
      dout_o  = {wb_lo, wb_lo};
      hi_en_o = 1'b1;
      lo_en_o = 1'b0;
    end
  end

  always_comb begin
    rdata_n = rdata_q;
    if (wide_i && word_i) begin
      rdata_n = din_i;
    end else if (wide_i) begin
      rdata_n = {{HALF{1'b0}}, (a0_i ? din_lo : din_hi)};
    end else if (word_i) begin
      if (phase_i) rdata_n[HALF-1:0]      = din_hi;
      else         rdata_n[DATA_W-1:HALF] = din_hi;
    end else begin
      rdata_n = {{HALF{1'b0}}, din_hi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture_i) begin
      rdata_q <= rdata_n;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ext_area_bus.sv
module ext_area_bus
  import ebi_pkg::*;
#(
  parameter  int unsigned ADDR_W    = 24,
  parameter  int unsigned AREAS     = 8,
  parameter  int unsigned DATA_W    = 16,
  localparam int unsigned AREA_BITS = $clog2(AREAS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AREAS-1:0]        cfg_wide_i,
  input  logic [AREAS-1:0]        cfg_slow_i,
  input  logic [AREAS*WAIT_W-1:0] cfg_wait_i,
  input  logic                    req_valid_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic                    req_word_i,
  input  logic                    req_write_i,
  input  logic [DATA_W-1:0]       req_wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    done_o,
  output logic [ADDR_W-1:0]       ext_addr_o,
  output logic [DATA_W-1:0]       ext_dout_o,
  input  logic [DATA_W-1:0]       ext_din_i,
  output logic                    ext_oe_o,
  output logic                    ext_rd_n_o,
  output logic                    ext_wr_hi_n_o,
  output logic                    ext_wr_lo_n_o,
  output logic [AREAS-1:0]        ext_cs_n_o
);
  logic rst_meta, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  logic [AREA_BITS-1:0] dec_area;
  area_cfg_t            dec_cfg;

  ebi_area_decode #(.ADDR_W(ADDR_W), .AREAS(AREAS)) u_decode (
    .addr_i     (req_addr_i),
    .cfg_wide_i (cfg_wide_i),
    .cfg_slow_i (cfg_slow_i),
    .cfg_wait_i (cfg_wait_i),
    .area_o     (dec_area),
    .cfg_o      (dec_cfg)
  );

  bus_st_e state;
  logic    phase, phase_end, start, busy, split;

  logic [ADDR_W-1:0]    addr_q;
  logic                 word_q, write_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [AREA_BITS-1:0] area_q;
  area_cfg_t            cfg_q;

  assign start = req_valid_i && (state == ST_IDLE);
  assign busy  = (state != ST_IDLE);
  assign split = word_q && !cfg_q.wide;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      addr_q  <= '0;
      word_q  <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
      area_q  <= '0;
      cfg_q   <= '0;
    end else if (start) begin
      addr_q  <= req_addr_i;
      word_q  <= req_word_i;
      write_q <= req_write_i;
      wdata_q <= req_wdata_i;
      area_q  <= dec_area;
      cfg_q   <= dec_cfg;
    end
  end

  ebi_bus_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start_i     (start),
    .slow_i      (cfg_q.slow),
    .waits_i     (cfg_q.waits),
    .split_i     (split),
    .state_o     (state),
    .phase_o     (phase),
    .phase_end_o (phase_end),
    .done_o      (done_o)
  );

  logic hi_en, lo_en;

  ebi_lane_steer #(.DATA_W(DATA_W)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wide_i    (cfg_q.wide),
    .word_i    (word_q),
    .a0_i      (addr_q[0]),
    .phase_i   (phase),
    .capture_i (phase_end && !write_q),
    .wdata_i   (wdata_q),
    .din_i     (ext_din_i),
    .dout_o    (ext_dout_o),
    .hi_en_o   (hi_en),
    .lo_en_o   (lo_en),
    .rdata_o   (rdata_o)
  );

  logic rd_win, wr_win;

  assign rd_win = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
  assign wr_win = (state == ST_T2) || (state == ST_TW);

  assign ext_addr_o    = {addr_q[ADDR_W-1:1], (word_q ? phase : addr_q[0])};
  assign ext_oe_o      = busy && write_q;
  assign ext_rd_n_o    = !(busy && !write_q && rd_win);
  assign ext_wr_hi_n_o = !(write_q && wr_win && hi_en);
  assign ext_wr_lo_n_o = !(write_q && wr_win && lo_en);

  for (genvar g = 0; g < AREAS; g++) begin : g_cs
    assign ext_cs_n_o[g] = !(busy && (area_q == AREA_BITS'(g)));
  end
endmodule

// File: rtl/ebi_bus_chk.sv
module ebi_bus_chk #(
  parameter  int unsigned ADDR_W    = 24,
  parameter  int unsigned AREAS     = 8,
  localparam int unsigned AREA_BITS = $clog2(AREAS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_o,
  input logic [ADDR_W-1:0] ext_addr_o,
  input logic              ext_rd_n_o,
  input logic              ext_wr_hi_n_o,
  input logic              ext_wr_lo_n_o,
  input logic [AREAS-1:0]  ext_cs_n_o
);
  logic any_cs;
  assign any_cs = (ext_cs_n_o != '1);

  // R1
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n_o));

  // R1
  cs_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_cs |-> !ext_cs_n_o[ext_addr_o[ADDR_W-1 -: AREA_BITS]]);

  // R2
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n_o || !ext_wr_hi_n_o || !ext_wr_lo_n_o) |-> any_cs);

  // R4
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rd_n_o |-> (ext_wr_hi_n_o && ext_wr_lo_n_o));

  // R4
  rd_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n_o && !$past(ext_rd_n_o)) |-> $stable(ext_addr_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!any_cs && ($past(ext_cs_n_o) != '1)));
endmodule

bind ext_area_bus ebi_bus_chk #(.ADDR_W(ADDR_W), .AREAS(AREAS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .done_o        (done_o),
  .ext_addr_o    (ext_addr_o),
  .ext_rd_n_o    (ext_rd_n_o),
  .ext_wr_hi_n_o (ext_wr_hi_n_o),
  .ext_wr_lo_n_o (ext_wr_lo_n_o),
  .ext_cs_n_o    (ext_cs_n_o)
);

// File: tb/ext_area_bus_bench.sv
module ext_area_bus_bench;
  logic        clk;
  logic        rst_n;
  logic [7:0]  cfg_wide, cfg_slow;
  logic [15:0] cfg_wait;
  logic        req_valid, req_word, req_write;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic [15:0] rdata;
  logic        done;
  logic [23:0] ext_addr;
  logic [15:0] ext_dout, ext_din;
  logic        ext_oe, ext_rd_n, ext_wr_hi_n, ext_wr_lo_n;
  logic [7:0]  ext_cs_n;

  int vecs;
  int errs;

  ext_area_bus u_ext_area_bus (
    .clk (clk), .rst_n (rst_n),
    .cfg_wide_i (cfg_wide), .cfg_slow_i (cfg_slow), .cfg_wait_i (cfg_wait),
    .req_valid_i (req_valid), .req_addr_i (req_addr), .req_word_i (req_word),
    .req_write_i (req_write), .req_wdata_i (req_wdata),
    .rdata_o (rdata), .done_o (done),
    .ext_addr_o (ext_addr), .ext_dout_o (ext_dout), .ext_din_i (ext_din),
    .ext_oe_o (ext_oe), .ext_rd_n_o (ext_rd_n),
    .ext_wr_hi_n_o (ext_wr_hi_n), .ext_wr_lo_n_o (ext_wr_lo_n),
    .ext_cs_n_o (ext_cs_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] mb(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  logic [2:0] din_area;
  always_comb begin
    din_area = ext_addr[23:21];
    if (cfg_wide[din_area])
      ext_din = {mb({ext_addr[23:1], 1'b0}), mb({ext_addr[23:1], 1'b1})};
    else
      ext_din = {mb(ext_addr), 8'hEE};
  end

  task automatic chk(input logic ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_access(input logic [2:0] ar, input logic wd, input logic sl,
                            input logic [1:0] w, input logic wo, input logic wrt,
                            input logic a0, input logic [15:0] seed);
    logic [23:0] addr, even, ba;
    logic [15:0] wdat, exp_rd;
    logic [7:0]  bv, ev;
    logic [1:0]  seen, want;
    int phases, n, cyc, done_cyc, cs_cnt, foreign, rd_cnt, wr_cnt, bad_wr;
    logic [7:0]  cs_first;
    string tag, lane_tag;

    addr   = {ar, seed[4:0], seed[15:1], a0};
    even   = {addr[23:1], 1'b0};
    wdat   = {seed[7:0], ~seed[15:8]};
    phases = (wo && !wd) ? 2 : 1;
    n      = sl ? 3 + int'(w) : 2;
    tag    = sl ? "R4" : ((w != 2'd0) ? "R5" : "R3");
    lane_tag = wd ? "R6" : "R7";
    cs_cnt = 0; foreign = 0; rd_cnt = 0; wr_cnt = 0; bad_wr = 0;
    seen = 2'b00; done_cyc = 0; cyc = 0; cs_first = 8'hFF;

    @(negedge clk);
    cfg_wide = wd ? (8'h01 << ar) : ~(8'h01 << ar);
    cfg_slow = sl ? (8'h01 << ar) : ~(8'h01 << ar);
    for (int k = 0; k < 8; k++) cfg_wait[2*k +: 2] = (k == int'(ar)) ? w : ~w;
    req_valid = 1'b1;
    req_addr  = addr;
    req_word  = wo;
    req_write = wrt;
    req_wdata = wdat;
    @(posedge clk);

    while (done_cyc == 0 && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        cs_first = ext_cs_n;
        req_addr = {ar ^ 3'd1, addr[20:0]};
      end
      if (cyc == 2) req_valid = 1'b0;
      for (int k = 0; k < 8; k++)
        if (!ext_cs_n[k]) begin
          if (k == int'(ar)) cs_cnt++;
          else foreign++;
        end
      if (!ext_rd_n) rd_cnt++;
      if (!ext_wr_hi_n || !ext_wr_lo_n) wr_cnt++;
      for (int l = 0; l < 2; l++) begin
        if ((l == 0 && !ext_wr_hi_n) || (l == 1 && !ext_wr_lo_n)) begin
          if (l == 0) begin
            ba = wd ? {ext_addr[23:1], 1'b0} : ext_addr;
            bv = ext_dout[15:8];
          end else begin
            ba = {ext_addr[23:1], 1'b1};
            bv = ext_dout[7:0];
          end
          ev = wo ? (ba[0] ? wdat[7:0] : wdat[15:8]) : wdat[7:0];
          if (ba[23:1] != addr[23:1] || (!wo && ba[0] != a0) || bv != ev) bad_wr++;
          seen[ba[0]] = 1'b1;
        end
      end
      if (done) done_cyc = cyc;
    end

    if (cyc >= 40 && done_cyc == 0)
      chk(1'b0, "R8 watchdog", 32'(cyc), 32'(phases * n + 1));
    chk(cs_first == ~(8'h01 << ar), "R1", 32'(cs_first), 32'(~(8'h01 << ar)));
    chk(cs_cnt == phases * n, "R2", 32'(cs_cnt), 32'(phases * n));
    chk(done_cyc == phases * n + 1, tag, 32'(done_cyc), 32'(phases * n + 1));
    chk(foreign == 0, "R9", 32'(foreign), 32'd0);
    if (wrt) begin
      chk(rd_cnt == 0, tag, 32'(rd_cnt), 32'd0);
      chk(wr_cnt == phases * (sl ? 1 + int'(w) : 1), tag, 32'(wr_cnt),
          32'(phases * (sl ? 1 + int'(w) : 1)));
      want = wo ? 2'b11 : (a0 ? 2'b10 : 2'b01);
      chk(bad_wr == 0 && seen == want, lane_tag, {bad_wr[23:0], 6'd0, seen},
          {24'd0, 6'd0, want});
    end else begin
      chk(wr_cnt == 0, tag, 32'(wr_cnt), 32'd0);
      chk(rd_cnt == phases * (sl ? 2 + int'(w) : 1), tag, 32'(rd_cnt),
          32'(phases * (sl ? 2 + int'(w) : 1)));
      exp_rd = wo ? {mb(even), mb({even[23:1], 1'b1})} : {8'h00, mb(addr)};
      chk(rdata == exp_rd, "R8", 32'(rdata), 32'(exp_rd));
    end

    @(negedge clk);
    chk(done == 1'b0, "R8", 32'(done), 32'd0);
    chk(ext_cs_n == 8'hFF, "R9", 32'(ext_cs_n), 32'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int seed;
    vecs = 0; errs = 0; seed = 1;
    rst_n = 1'b0;
    cfg_wide = '0; cfg_slow = '0; cfg_wait = '0;
    req_valid = 1'b0; req_addr = '0; req_word = 1'b0;
    req_write = 1'b0; req_wdata = '0;
    repeat (3) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    // R10: reset state with a request pending
    chk(ext_cs_n == 8'hFF, "R10", 32'(ext_cs_n), 32'hFF);
    chk({ext_rd_n, ext_wr_hi_n, ext_wr_lo_n} == 3'b111, "R10",
        32'({ext_rd_n, ext_wr_hi_n, ext_wr_lo_n}), 32'h7);
    chk(done == 1'b0, "R10", 32'(done), 32'd0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int ar = 0; ar < 8; ar++)
      for (int wd = 0; wd < 2; wd++)
        for (int sl = 0; sl < 2; sl++)
          for (int w = 0; w < 4; w++)
            for (int wo = 0; wo < 2; wo++)
              for (int wr = 0; wr < 2; wr++)
                for (int a0 = 0; a0 < 2; a0++) begin
                  seed = (seed * 1103 + 12345) & 16'hFFFF;
                  run_access(3'(ar), wd[0], sl[0], 2'(w), wo[0], wr[0], a0[0],
                             16'(seed));
                end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule